// File: doc/BRIEF.md
# Programmable External Clock Output Generator

This block produces one clock for an external pin. A single 32-bit control word decides four things: whether the pin toggles, which reference clock feeds it, a power-of-two prescale of 1, 2, 4 or 8, and an integer divide from 1 to 32. The block can only divide, so the output never runs faster than the reference that is selected.

There are three references. The first is made inside the block by dividing the fast oscillator by a fixed ratio, 750 by default, which turns 24 MHz into 32 kHz. The other two are the external slow crystal clock and the fast oscillator itself.

Software writes the control word through a plain write strobe and can read it back at any time. Changes to the divider are loaded only at the end of an output period, so the pin never carries a runt pulse. A change of source goes through a break-before-make handover between the reference clocks.

Top module: `clkoutGen`

## Requirements
- R1: After reset the read-back word is zero and `clkOut` is low and stays low: the output is disabled, source 0 is selected, and both divider fields are zero.
- R2: The control word has fixed bit positions. Bit 31 is the enable, bits 25:24 are the source code, bits 21:20 are the prescale exponent P, and bits 12:8 are the divide field M. Every other bit reads as zero and ignores writes. The fields read back exactly as written, including source code 3.
- R3: When the enable bit is cleared, `clkOut` finishes its current period, then stays low. When the enable bit is set again, the first high phase has its full length.
- R4: Source code 0 selects the internal divided reference, code 1 selects `oscLf`, and codes 2 and 3 both select `oscHf`.
- R5: The internal reference has a period of exactly PRE_DIV (default 750) periods of `oscHf`.
- R6: The output period is the source period × 2^P × (M+1).
- R7: With M+1 ≥ 2, the output is high for ceil((M+1)/2) × 2^P source periods. With M = 0 and P > 0, it is high for half its period.
- R8: With M = 0 and P = 0, `clkOut` follows the selected source: same period, same high time.
- R9: A new M or P value is loaded only at an output period boundary. While the settings change, no high phase or low phase is shorter than the shortest phase of the old and new settings.
- R10: When the source changes, at most one reference is gated into the divider at any time. No output phase is shorter than the shortest phase of the old and new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Clock of the register port |
| rstN | input | 1 | Asynchronous active-low reset for every domain |
| wrEn | input | 1 | Write strobe, sampled on the rising edge of `regClk` |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word, reserved bits zero |
| oscHf | input | 1 | Fast oscillator; also feeds the internal fixed divider |
| oscLf | input | 1 | Slow crystal reference |
| clkOut | output | 1 | Divided and gated output clock |

## Verification
The assertions watch the register port and the source handover on every cycle. They check that a write shows up in the read-back word masked to the four fields, that the word holds when no write is made, that reserved bits read zero, that the word is zero just after reset, and that no two reference gates are open together. Period length, high time, the fixed pre-divide and the absence of runt pulses during setting and source changes are timing relations across clock domains. Only the bench's scenarios show these: it times the edges of `clkOut` for a sweep of divide and prescale values on each source and compares them with the arithmetic of the requirements.

// File: rtl/clkoutPkg.sv
`timescale 1ns/1ps
package clkoutPkg;
  localparam int M_W     = 5;
  localparam int P_W     = 2;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 3;

  localparam int EN_BIT  = 31;
  localparam int SEL_LSB = 24;
  localparam int P_LSB   = 20;
  localparam int M_LSB   = 8;

  localparam logic [31:0] FIELD_MASK =
      (32'd1 << EN_BIT)
    | (32'((1 << SEL_W) - 1) << SEL_LSB)
    | (32'((1 << P_W) - 1) << P_LSB)
    | (32'((1 << M_W) - 1) << M_LSB);

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [P_W-1:0]   p;
    logic [M_W-1:0]   m;
  } cfg_t;
endpackage

// File: rtl/clkoutCtrl.sv
`timescale 1ns/1ps
module clkoutCtrl
  import clkoutPkg::*;
(
  input  logic        regClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output cfg_t        cfg
);
  cfg_t cfgQ;

  always_ff @(posedge regClk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrEn) begin
      cfgQ.en  <= wrData[EN_BIT];
      cfgQ.sel <= wrData[SEL_LSB +: SEL_W];
      cfgQ.p   <= wrData[P_LSB +: P_W];
      cfgQ.m   <= wrData[M_LSB +: M_W];
    end
  end

  always_comb begin
    rdData                   = '0;
    rdData[EN_BIT]           = cfgQ.en;
    rdData[SEL_LSB +: SEL_W] = cfgQ.sel;
    rdData[P_LSB +: P_W]     = cfgQ.p;
    rdData[M_LSB +: M_W]     = cfgQ.m;
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/clkoutSrc.sv
`timescale 1ns/1ps
module clkoutSrc
  import clkoutPkg::*;
#(
  parameter int PRE_DIV = 750
) (
  input  logic               oscHf,
  input  logic               oscLf,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SRC-1:0] gateVec,
  output logic               clkSel
);
  localparam int HALF = PRE_DIV / 2;
  localparam int PCW  = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PCW-1:0]     preCnt;
  logic               preClk;
  logic [NUM_SRC-1:0] refs;
  logic [NUM_SRC-1:0] hit;

  // fixed even pre-divider of the fast oscillator, 50 % duty
  always_ff @(posedge oscHf or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      preClk <= 1'b0;
    end else if (preCnt == PCW'(HALF - 1)) begin
      preCnt <= '0;
      preClk <= ~preClk;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign refs = {oscHf, oscLf, preClk};

  // break-before-make handover: each gate opens only when every other gate is shut
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    logic stageA;
    logic gateQ;
    logic othersOn;

    if (i == NUM_SRC - 1) begin : g_top
      assign hit[i] = (sel >= SEL_W'(i));
    end else begin : g_low
      assign hit[i] = (sel == SEL_W'(i));
    end

    assign othersOn = |(gateVec & ~(NUM_SRC'(1) << i));

    always_ff @(negedge refs[i] or negedge rstN) begin
      if (!rstN) begin
        stageA <= 1'b0;
        gateQ  <= 1'b0;
      end else begin
        stageA <= hit[i] && !othersOn;
        gateQ  <= stageA;
      end
    end

    assign gateVec[i] = gateQ;
  end

  assign clkSel = |(refs & gateVec);
endmodule

// File: rtl/clkoutDiv.sv
`timescale 1ns/1ps
module clkoutDiv
  import clkoutPkg::*;
(
  input  logic clkSel,
  input  logic rstN,
  input  cfg_t cfg,
  output logic clkOut
);
  localparam int NW = M_W + 1;
  localparam int DW = NW + (1 << P_W) - 1;
  localparam int SW = 1 + P_W + M_W;

  logic [SW-1:0]  syncA, syncB;
  logic           enNew;
  logic [P_W-1:0] pNew;
  logic [M_W-1:0] mNew;
  logic [NW-1:0]  nNew;
  logic [DW-1:0]  dNew, hNew;

  logic [DW-1:0]  cnt, dLast, hAct;
  logic           enAct, bypass, divReg, gateLo, boundary;

  // settings cross into the divided domain through two flops
  always_ff @(posedge clkSel or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {cfg.en, cfg.p, cfg.m};
      syncB <= syncA;
    end
  end

  assign {enNew, pNew, mNew} = syncB;
  assign nNew = NW'(mNew) + 1'b1;
  assign dNew = DW'(nNew) << pNew;
  assign hNew = (nNew == NW'(1)) ? ((DW'(1) << pNew) >> 1)
                                 : (DW'((nNew + 1'b1) >> 1) << pNew);

  assign boundary = !enAct || (cnt == dLast);

  always_ff @(posedge clkSel or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      dLast  <= '0;
      hAct   <= '0;
      enAct  <= 1'b0;
      bypass <= 1'b0;
      divReg <= 1'b0;
    end else if (boundary) begin
      enAct  <= enNew;
      dLast  <= dNew - 1'b1;
      hAct   <= hNew;
      bypass <= (dNew == DW'(1));
      cnt    <= '0;
      divReg <= enNew && (dNew != DW'(1));
    end else begin
      cnt    <= cnt + 1'b1;
      divReg <= (cnt + 1'b1) < hAct;
    end
  end

  // pass-through gate changes only while the source is low
  always_ff @(negedge clkSel or negedge rstN) begin
    if (!rstN) gateLo <= 1'b0;
    else       gateLo <= enAct && bypass;
  end

  assign clkOut = divReg | (clkSel & gateLo);
endmodule

// File: rtl/clkoutGen.sv
`timescale 1ns/1ps
module clkoutGen
  import clkoutPkg::*;
#(
  parameter int PRE_DIV = 750
) (
  input  logic        regClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        oscHf,
  input  logic        oscLf,
  output logic        clkOut
);
  cfg_t               cfg;
  logic [NUM_SRC-1:0] gateVec;
  logic               clkSel;

  clkoutCtrl u_ctrl (
    .regClk (regClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .cfg    (cfg)
  );

  clkoutSrc #(.PRE_DIV(PRE_DIV)) u_src (
    .oscHf   (oscHf),
    .oscLf   (oscLf),
    .rstN    (rstN),
    .sel     (cfg.sel),
    .gateVec (gateVec),
    .clkSel  (clkSel)
  );

  clkoutDiv u_div (
    .clkSel (clkSel),
    .rstN   (rstN),
    .cfg    (cfg),
    .clkOut (clkOut)
  );
endmodule

// File: rtl/clkoutGenChk.sv
`timescale 1ns/1ps
module clkoutGenChk
  import clkoutPkg::*;
(
  input logic               regClk,
  input logic               rstN,
  input logic               wrEn,
  input logic [31:0]        wrData,
  input logic [31:0]        rdData,
  input logic               oscHf,
  input logic [NUM_SRC-1:0] gateVec
);
  assert_reset_zero_R1: assert property (@(posedge regClk) disable iff (!rstN)
    $rose(rstN) |-> (rdData == 32'd0));

  assert_readback_R2: assert property (@(posedge regClk) disable iff (!rstN)
    wrEn |=> (rdData == ($past(wrData) & FIELD_MASK)));

  assert_hold_R2: assert property (@(posedge regClk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  assert_reserved_zero_R2: assert property (@(posedge regClk) disable iff (!rstN)
    (rdData & ~FIELD_MASK) == 32'd0);

  assert_gate_onehot_R10: assert property (@(posedge oscHf) disable iff (!rstN)
    $onehot0(gateVec));
endmodule

bind clkoutGen clkoutGenChk u_chk (
  .regClk  (regClk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .oscHf   (oscHf),
  .gateVec (gateVec)
);

// File: tb/clkoutGen_tb.sv
`timescale 1ns/1ps
module clkoutGen_tb;
  localparam real HF_PER  = 40.0;
  localparam real LF_PER  = 310.0;
  localparam int  PRE_DIV = 750;

  logic        regClk = 1'b0;
  logic        oscHf  = 1'b0;
  logic        oscLf  = 1'b0;
  logic        rstN;
  logic        wrEn   = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkOut;

  int checks = 0;
  int fails  = 0;
  int riseCnt = 0;

  bit  monOn = 1'b0;
  real tRise = -1.0, tFall = -1.0;
  real minHi = 1.0e12, minLo = 1.0e12;

  always #5   regClk = ~regClk;
  always #20  oscHf  = ~oscHf;
  always #155 oscLf  = ~oscLf;

  clkoutGen #(.PRE_DIV(PRE_DIV)) u_dut (
    .regClk (regClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .oscHf  (oscHf),
    .oscLf  (oscLf),
    .clkOut (clkOut)
  );

  always @(posedge clkOut) begin
    riseCnt++;
    if (monOn && tFall >= 0.0 && ($realtime - tFall) < minLo) minLo = $realtime - tFall;
    tRise = $realtime;
  end

  always @(negedge clkOut) begin
    if (monOn && tRise >= 0.0 && ($realtime - tRise) < minHi) minHi = $realtime - tRise;
    tFall = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0.1f expected=%0.1f", req, what, act, exp);
    end
  endtask

  task automatic chkNear(input string req, input string what, input real act, input real exp);
    chk((act - exp < 0.5) && (exp - act < 0.5), req, what, act, exp);
  endtask

  function automatic real srcPer(input int sel);
    if (sel == 0)      return HF_PER * PRE_DIV;
    else if (sel == 1) return LF_PER;
    else               return HF_PER;
  endfunction

  function automatic real expPer(input int sel, input int p, input int m);
    return srcPer(sel) * (1 << p) * (m + 1);
  endfunction

  function automatic real expHi(input int sel, input int p, input int m);
    int n = m + 1;
    if (n == 1) return srcPer(sel) * (1 << p) / 2.0;
    return srcPer(sel) * (1 << p) * ((n + 1) / 2);
  endfunction

  function automatic logic [31:0] cfgWord(input int en, input int sel, input int p, input int m);
    return (32'(en) << 31) | (32'(sel) << 24) | (32'(p) << 20) | (32'(m) << 8);
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge regClk);
    wrEn   = 1'b1;
    wrData = v;
    @(negedge regClk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic measure(output real hi, output real per);
    real t0, t1, t2;
    @(posedge clkOut); t0 = $realtime;
    @(negedge clkOut); t1 = $realtime;
    @(posedge clkOut); t2 = $realtime;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic settleMeasure(output real hi, output real per);
    repeat (4) @(posedge clkOut);
    measure(hi, per);
  endtask

  task automatic monStart();
    minHi = 1.0e12;
    minLo = 1.0e12;
    tRise = -1.0;
    tFall = -1.0;
    monOn = 1'b1;
  endtask

  task automatic runCfg(input string reqP, input string reqH, input int sel, input int p, input int m);
    real hi, per;
    wr(cfgWord(1, sel, p, m));
    settleMeasure(hi, per);
    chkNear(reqP, $sformatf("period sel=%0d p=%0d m=%0d", sel, p, m), per, expPer(sel, p, m));
    chkNear(reqH, $sformatf("high sel=%0d p=%0d m=%0d", sel, p, m), hi, expHi(sel, p, m));
  endtask

  initial begin
    #1_800_000;
    fails++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=0", riseCnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mList[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 15, 16, 30, 31};
    real hi, per;
    int  r0;

    rstN = 1'b0;
    repeat (10) @(negedge regClk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge regClk);
    chk(rdData == 32'd0, "R1", "read-back after reset", real'(rdData), 0.0);
    #5000;
    chk(clkOut == 1'b0, "R1", "clkOut after reset", real'(clkOut), 0.0);
    chk(riseCnt == 0, "R1", "edges while disabled after reset", real'(riseCnt), 0.0);

    // R2: field layout, reserved bits
    wr(32'hFFFF_FFFF);
    chk(rdData == 32'h8330_1F00, "R2", "all-ones write read-back", real'(rdData), real'(32'h8330_1F00));
    wr(32'h00CC_E0FF);
    chk(rdData == 32'd0, "R2", "reserved-only write read-back", real'(rdData), 0.0);

    // R2, R4: source code 3 reads back and selects the fast oscillator
    wr(cfgWord(1, 3, 0, 2));
    chk(rdData == cfgWord(1, 3, 0, 2), "R2", "source code 3 read-back", real'(rdData), real'(cfgWord(1, 3, 0, 2)));
    settleMeasure(hi, per);
    chkNear("R4", "code 3 period", per, expPer(2, 0, 2));

    // R6, R7, R8: sweep on the fast oscillator
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 12; k++) begin
        if (p == 0 && mList[k] == 0) runCfg("R8", "R8", 2, p, mList[k]);
        else                         runCfg("R6", "R7", 2, p, mList[k]);
      end
    end

    // R4, R6, R7: slow crystal source
    for (int p = 0; p < 4; p++) runCfg("R4", "R7", 1, p, 2);
    runCfg("R4", "R8", 1, 0, 0);

    // R5, R8: internal divided source
    runCfg("R5", "R8", 0, 0, 0);
    runCfg("R5", "R7", 0, 0, 1);

    // R3: disable stops low, enable restarts with full first high phase
    wr(cfgWord(1, 2, 0, 3));
    settleMeasure(hi, per);
    wr(cfgWord(0, 2, 0, 3));
    #2000;
    r0 = riseCnt;
    #3000;
    chk(clkOut == 1'b0, "R3", "clkOut level while disabled", real'(clkOut), 0.0);
    chk(riseCnt == r0, "R3", "edges while disabled", real'(riseCnt - r0), 0.0);
    wr(cfgWord(1, 2, 0, 3));
    measure(hi, per);
    chkNear("R3", "first high phase after enable", hi, expHi(2, 0, 3));

    // R3: disable from pass-through mode
    wr(cfgWord(1, 2, 0, 0));
    settleMeasure(hi, per);
    wr(cfgWord(0, 2, 0, 0));
    #500;
    r0 = riseCnt;
    #2000;
    chk(clkOut == 1'b0 && riseCnt == r0, "R3", "pass-through disable edges", real'(riseCnt - r0), 0.0);

    // R9: divider changes at arbitrary times
    wr(cfgWord(1, 2, 0, 5));
    settleMeasure(hi, per);
    monStart();
    #37;  wr(cfgWord(1, 2, 0, 2));
    #1130; wr(cfgWord(1, 2, 0, 9));
    #2210; wr(cfgWord(1, 2, 1, 2));
    #3000;
    monOn = 1'b0;
    chk(minHi > 79.5, "R9", "shortest high during divider changes", minHi, 80.0);
    chk(minLo > 39.5, "R9", "shortest low during divider changes", minLo, 40.0);

    // R10: source changes
    wr(cfgWord(1, 2, 0, 3));
    settleMeasure(hi, per);
    monStart();
    #53;   wr(cfgWord(1, 1, 0, 3));
    #10000; wr(cfgWord(1, 2, 0, 3));
    #5000;
    monOn = 1'b0;
    chk(minHi > 79.5, "R10", "shortest high across source change", minHi, 80.0);
    chk(minLo > 79.5, "R10", "shortest low across source change", minLo, 80.0);
    settleMeasure(hi, per);
    chkNear("R10", "period after switching back", per, expPer(2, 0, 3));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule